// File: doc/BRIEF.md
# Packet-Granular Round-Robin Input Arbiter

This block merges five packet streams into a single output stream. Four of the inputs come from Ethernet port interfaces and the fifth comes from a host DMA path. Each input writes into its own small first-word-fall-through FIFO. An arbiter then moves whole packets from those FIFOs to the output. Every beat carries a 256-bit data word, a byte-enable mask (TKEEP), an end-of-packet flag (TLAST) and a metadata word (TUSER).

The arbiter is a two-state machine. In `ST_IDLE` it searches for a non-empty FIFO, starting at the round-robin pointer, and skips empty ones. When it finds one it records the grant and takes transition `T_GRANT` into `ST_SEND`. In `ST_SEND` it presents the head of the granted FIFO on the output. A FIFO entry is popped only on a beat where output valid and ready are both high. On the beat where TLAST is accepted, it takes transition `T_RELEASE` back to `ST_IDLE` and moves the pointer to the input after the one just served. While neither condition holds, the machine stays where it is (`T_WAIT` in `ST_IDLE`, `T_BEAT` in `ST_SEND`). Downstream backpressure stalls the packet in progress and never splits it.

Top module: `pkt_rr_arbiter`

## Requirements
- R1: Each input has its own FIFO. The beats of a packet leave the block in order, with TDATA, TKEEP, TUSER and TLAST unchanged.
- R2: An input's `s_tready` bit is low while its FIFO holds `FIFO_DEPTH` entries (default 16), and no beat is accepted on that input in that state.
- R3: The search for the next packet starts at the input after the last one served, in the index order 0,1,2,3,4 wrapping to 0. Inputs whose FIFO is empty are skipped.
- R4: Once an input is granted, all beats up to and including its TLAST beat are forwarded before any beat from another input appears.
- R5: While `m_tvalid` is high and `m_tready` is low, the next cycle still has `m_tvalid` high, with `m_tdata`, `m_tkeep`, `m_tuser` and `m_tlast` unchanged, and no FIFO is popped.
- R6: The grant is released on the cycle where a TLAST beat is accepted. The following cycle is spent in `ST_IDLE` with `m_tvalid` low.
- R7: After reset, `m_tvalid` is low, every `s_tready` bit is high, and the round-robin pointer is at input 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_tdata | input | N_IN x DATA_W | Per-input data words |
| s_tkeep | input | N_IN x DATA_W/8 | Per-input byte enables |
| s_tuser | input | N_IN x USER_W | Per-input metadata |
| s_tlast | input | N_IN | Per-input end of packet |
| s_tvalid | input | N_IN | Per-input beat valid |
| s_tready | output | N_IN | Per-input ready (FIFO not full) |
| m_tdata | output | DATA_W | Output data |
| m_tkeep | output | DATA_W/8 | Output byte enables |
| m_tuser | output | USER_W | Output metadata |
| m_tlast | output | 1 | Output end of packet |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream ready |

## Verification
The bound checker watches four things on every cycle: that a stalled output beat stays stable, that at most one FIFO pops and only on an accepted beat, that the grant stays fixed inside a packet, and that an idle cycle follows each accepted TLAST. The bench's scenarios cover the rest. They show the exact round-robin order from the reset pointer, the skipping of empty inputs, the FIFO filling to its depth with ready dropping, and the data, keep and metadata values arriving intact.

// File: rtl/pkt_rr_arbiter_pkg.sv
package pkt_rr_arbiter_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } arb_state_e;
endpackage

// File: rtl/pkt_fwft_fifo.sv
module pkt_fwft_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             not_empty,
    output logic             not_full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [AW:0]      count;
    logic             do_push, do_pop;

    assign not_empty = (count != '0);
    assign not_full  = (count != (AW+1)'(DEPTH));
    assign do_push   = push && not_full;
    assign do_pop    = pop && not_empty;
    assign dout      = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/pkt_rr_pick.sv
module pkt_rr_pick #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] base,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = int'(base) + k;
            if (j >= N) j = j - N;
            if (!found && req[j]) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/pkt_rr_arbiter.sv
module pkt_rr_arbiter
    import pkt_rr_arbiter_pkg::*;
#(
    parameter int N_IN       = 5,
    parameter int DATA_W     = 256,
    parameter int USER_W     = 128,
    parameter int FIFO_DEPTH = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_IN-1:0][DATA_W-1:0]    s_tdata,
    input  logic [N_IN-1:0][DATA_W/8-1:0]  s_tkeep,
    input  logic [N_IN-1:0][USER_W-1:0]    s_tuser,
    input  logic [N_IN-1:0]                s_tlast,
    input  logic [N_IN-1:0]                s_tvalid,
    output logic [N_IN-1:0]                s_tready,
    output logic [DATA_W-1:0]              m_tdata,
    output logic [DATA_W/8-1:0]            m_tkeep,
    output logic [USER_W-1:0]              m_tuser,
    output logic                           m_tlast,
    output logic                           m_tvalid,
    input  logic                           m_tready
);
    localparam int KEEP_W = DATA_W / 8;
    localparam int ENT_W  = DATA_W + KEEP_W + USER_W + 1;
    localparam int IW     = (N_IN > 1) ? $clog2(N_IN) : 1;

    arb_state_e             state_q, state_d;
    logic [IW-1:0]          grant_q, grant_d;
    logic [IW-1:0]          ptr_q, ptr_d;
    logic [N_IN-1:0]        head_vld;
    logic [N_IN-1:0]        pop;
    logic [ENT_W-1:0]       head [N_IN];
    logic                   pick_found;
    logic [IW-1:0]          pick_idx;
    logic                   fire_last;

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        pkt_fwft_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENT_W)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (s_tvalid[i]),
            .din       ({s_tlast[i], s_tuser[i], s_tkeep[i], s_tdata[i]}),
            .pop       (pop[i]),
            .dout      (head[i]),
            .not_empty (head_vld[i]),
            .not_full  (s_tready[i])
        );
        assign pop[i] = (state_q == ST_SEND) && (grant_q == IW'(i)) && m_tready && head_vld[i];
    end

    pkt_rr_pick #(.N(N_IN), .IW(IW)) u_pick (
        .req   (head_vld),
        .base  (ptr_q),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // Output process: head of the granted FIFO
    always_comb begin
        {m_tlast, m_tuser, m_tkeep, m_tdata} = head[grant_q];
        m_tvalid = (state_q == ST_SEND) && head_vld[grant_q];
    end

    assign fire_last = m_tvalid && m_tready && m_tlast;

    // Next-state process
    always_comb begin
        state_d = state_q;
        grant_d = grant_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_found) begin          // T_GRANT
                    grant_d = pick_idx;
                    state_d = ST_SEND;
                end                            // else T_WAIT
            end
            ST_SEND: begin
                if (fire_last) begin           // T_RELEASE
                    ptr_d   = (grant_q == IW'(N_IN-1)) ? '0 : grant_q + 1'b1;
                    state_d = ST_IDLE;
                end                            // else T_BEAT
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grant_q <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            grant_q <= grant_d;
            ptr_q   <= ptr_d;
        end
    end
endmodule

// File: rtl/pkt_rr_arbiter_checker.sv
module pkt_rr_arbiter_checker
    import pkt_rr_arbiter_pkg::*;
#(
    parameter int N_IN   = 5,
    parameter int DATA_W = 256,
    parameter int USER_W = 128,
    parameter int IW     = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [DATA_W-1:0]     m_tdata,
    input logic [DATA_W/8-1:0]   m_tkeep,
    input logic [USER_W-1:0]     m_tuser,
    input logic                  m_tlast,
    input logic                  m_tvalid,
    input logic                  m_tready,
    input arb_state_e            state_q,
    input logic [IW-1:0]         grant_q,
    input logic [N_IN-1:0]       pop
);
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tkeep)
                                      && $stable(m_tuser) && $stable(m_tlast)));

    p_pop_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop != '0) |-> (m_tvalid && m_tready));

    p_one_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));

    p_grant_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SEND) && !(m_tvalid && m_tready && m_tlast))
            |=> ((state_q == ST_SEND) && (grant_q == $past(grant_q))));

    p_release_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready && m_tlast) |=> (!m_tvalid && (state_q == ST_IDLE)));
endmodule

bind pkt_rr_arbiter pkt_rr_arbiter_checker #(
    .N_IN(N_IN), .DATA_W(DATA_W), .USER_W(USER_W), .IW(IW)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tuser(m_tuser),
    .m_tlast(m_tlast), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .state_q(state_q), .grant_q(grant_q), .pop(pop)
);

// File: tb/pkt_rr_arbiter_bench.sv
`timescale 1ns/1ps
module pkt_rr_arbiter_bench;
    localparam int N  = 5;
    localparam int DW = 256;
    localparam int KW = 32;
    localparam int UW = 128;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0][DW-1:0] s_tdata = '0;
    logic [N-1:0][KW-1:0] s_tkeep = '0;
    logic [N-1:0][UW-1:0] s_tuser = '0;
    logic [N-1:0]         s_tlast = '0;
    logic [N-1:0]         s_tvalid = '0;
    logic [N-1:0]         s_tready;
    logic [DW-1:0] m_tdata;
    logic [KW-1:0] m_tkeep;
    logic [UW-1:0] m_tuser;
    logic m_tlast, m_tvalid;
    logic m_tready = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pkt_rr_arbiter u_pkt_rr_arbiter (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tuser(s_tuser),
        .s_tlast(s_tlast), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tuser(m_tuser),
        .m_tlast(m_tlast), .m_tvalid(m_tvalid), .m_tready(m_tready)
    );

    function automatic logic [DW-1:0] mk_data(int p, int k, int b);
        return {8{8'(p), 8'(k), 16'(b)}};
    endfunction
    function automatic logic [UW-1:0] mk_user(int p, int k);
        return {96'h0, 8'hA5, 8'(k), 8'(p), 8'h5A};
    endfunction
    function automatic logic [KW-1:0] mk_keep(bit last);
        return last ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Output recorder and per-cycle stall/gap checks, sampled at negedge
    logic [DW-1:0] o_data [64];
    logic [KW-1:0] o_keep [64];
    logic [UW-1:0] o_user [64];
    logic          o_last [64];
    int out_n = 0;
    bit stall_pend = 0;
    bit last_pend  = 0;
    logic [DW+KW+UW:0] stall_snap;

    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_pend) begin
                check(m_tvalid && ({m_tlast, m_tuser, m_tkeep, m_tdata} == stall_snap),
                      "R5", "stalled beat changed", longint'(m_tdata[31:0]), longint'(stall_snap[31:0]));
            end
            if (last_pend) begin
                check(!m_tvalid, "R6", "valid in cycle after TLAST", longint'(m_tvalid), 0);
            end
            stall_pend = m_tvalid && !m_tready;
            stall_snap = {m_tlast, m_tuser, m_tkeep, m_tdata};
            last_pend  = m_tvalid && m_tready && m_tlast;
            if (m_tvalid && m_tready && out_n < 64) begin
                o_data[out_n] = m_tdata;
                o_keep[out_n] = m_tkeep;
                o_user[out_n] = m_tuser;
                o_last[out_n] = m_tlast;
                out_n++;
            end
        end else begin
            stall_pend = 0;
            last_pend  = 0;
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // Load nb-beat packets (id k) into every input in mask, same cycles
    task automatic load(logic [N-1:0] mask, int nb, int k);
        for (int b = 0; b < nb; b++) begin
            for (int p = 0; p < N; p++) begin
                s_tdata[p] = mk_data(p, k, b);
                s_tkeep[p] = mk_keep(b == nb - 1);
                s_tuser[p] = mk_user(p, k);
                s_tlast[p] = (b == nb - 1);
            end
            s_tvalid = mask;
            step();
        end
        s_tvalid = '0;
        s_tlast  = '0;
    endtask

    task automatic drain(int nbeats);
        m_tready = 1'b1;
        for (int c = 0; c < 400 && out_n < nbeats; c++) step();
        step();
        step();
        m_tready = 1'b0;
    endtask

    // Check packets in the capture buffer: expected source order, nb beats each
    task automatic check_order(int exp_src[$], int nb, int k, string req);
        int pos = 0;
        check(out_n == exp_src.size() * nb, req, "beat count", out_n, exp_src.size() * nb);
        foreach (exp_src[q]) begin
            for (int b = 0; b < nb; b++) begin
                if (pos < out_n) begin
                    check(o_user[pos] == mk_user(exp_src[q], k), req, "source order / contiguity",
                          longint'(o_user[pos][15:8]), exp_src[q]);
                    check(o_data[pos] == mk_data(exp_src[q], k, b) && o_last[pos] == (b == nb - 1)
                          && o_keep[pos] == mk_keep(b == nb - 1), "R1", "beat content",
                          longint'(o_data[pos][31:0]), longint'(mk_data(exp_src[q], k, b)));
                end
                pos++;
            end
        end
    endtask

    task automatic t_reset_r7();
        check(m_tvalid == 1'b0, "R7", "m_tvalid after reset", m_tvalid, 0);
        check(s_tready == '1, "R7", "s_tready after reset", s_tready, 5'h1F);
    endtask

    // All inputs loaded at once: pointer at 0 after reset gives 0,1,2,3,4
    task automatic t_rr_all_r3();
        int exp[$] = '{0, 1, 2, 3, 4};
        out_n = 0;
        load(5'b11111, 2, 1);
        drain(10);
        check_order(exp, 2, 1, "R3");
    endtask

    // Single packet on input 2 (pointer 0, 0 and 1 skipped); pointer then 3
    task automatic t_single_r1();
        int exp[$] = '{2};
        out_n = 0;
        load(5'b00100, 3, 2);
        drain(3);
        check_order(exp, 3, 2, "R1");
    endtask

    // Inputs 0 and 3 loaded, pointer at 3: expect 3 then 0, with a stall pattern
    task automatic t_skip_stall_r3();
        int exp[$] = '{3, 0};
        out_n = 0;
        load(5'b01001, 4, 3);
        for (int c = 0; c < 80 && out_n < 8; c++) begin
            m_tready = c[0] | c[2];
            step();
        end
        m_tready = 1'b0;
        step();
        check_order(exp, 4, 3, "R3");
    endtask

    // Fill input 1 without TLAST while output is stalled
    task automatic t_full_r2();
        int acc = 0;
        bit saw_full = 0;
        out_n = 0;
        m_tready = 1'b0;
        for (int c = 0; c < 40 && !saw_full; c++) begin
            s_tdata[1] = mk_data(1, 4, acc);
            s_tkeep[1] = '1;
            s_tuser[1] = mk_user(1, 4);
            s_tlast[1] = 1'b0;
            s_tvalid[1] = 1'b1;
            @(negedge clk);
            if (s_tready[1]) acc++;
            else saw_full = 1;
            @(posedge clk);
            #2;
        end
        check(saw_full && acc == DEPTH, "R2", "beats accepted before ready low", acc, DEPTH);
        step();
        check(s_tready[1] == 1'b0, "R2", "ready stays low while full", s_tready[1], 0);
        check(out_n == 0, "R5", "no beat leaves while m_tready low", out_n, 0);
        s_tvalid[1] = 1'b0;
        // drain the body, then append the closing beat
        drain(DEPTH);
        s_tdata[1] = mk_data(1, 4, DEPTH);
        s_tlast[1] = 1'b1;
        s_tvalid[1] = 1'b1;
        step();
        s_tvalid[1] = 1'b0;
        s_tlast[1] = 1'b0;
        drain(DEPTH + 1);
        check(out_n == DEPTH + 1, "R2", "all beats delivered, none lost", out_n, DEPTH + 1);
        check(o_last[DEPTH] == 1'b1 && o_data[DEPTH] == mk_data(1, 4, DEPTH), "R4",
              "closing beat after body", longint'(o_data[DEPTH][31:0]), longint'(mk_data(1, 4, DEPTH)));
    endtask

    // Input 2 holds two packets, input 3 one; pointer at 2 -> 2,3,then 2 again
    task automatic t_back_to_back_r6();
        int exp[$] = '{2, 3, 2};
        out_n = 0;
        load(5'b01100, 2, 5);
        load(5'b00100, 2, 5);
        drain(6);
        check_order(exp, 2, 5, "R6");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r7();
        step();
        t_rr_all_r3();
        t_single_r1();
        t_skip_stall_r3();
        t_full_r2();
        t_back_to_back_r6();
        repeat (4) step();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule